// File: doc/BRIEF.md
# Programmable Colour Matrix Converter

This block converts a stream of three-component, 8-bit pixels with a programmable 3x3 matrix and a signed offset per output row. Each output component is the rounded, offset and saturated dot product of one coefficient row with the input pixel. Loading different coefficient sets turns the same hardware into RGB to YCbCr (601 or 709, limited range), YCbCr to RGB, or full-to-limited range RGB compression.

The 24-byte coefficient bank is written one byte at a time through a small register port. The display pipeline drives pixels with a valid strobe and the line, frame and data-enable timing signals. All of these come out three register stages later, aligned with the converted pixel. Two per-pixel controls travel with each pixel. One selects the matrix or a straight pass-through. The other exchanges the first and third output components.

Top module: `colour_matrix3`

## Requirements
- R1: The bank is bytes 0..23. Row r (r = 0, 1, 2) starts at byte 8r and holds four 16-bit words: the multipliers for input components 0, 1 and 2, then the offset. The even byte of each word is the high byte. A write happens on a rising clock edge with `cfg_we` high. Writes to addresses 24..31 change nothing.
- R2: A multiplier word uses bit 12 as the sign (1 = negative) and bits 11:0 as the magnitude, with 10 fractional bits. Bits 15:13 are ignored. An offset word uses bit 9 as the sign and bits 8:0 as an integer magnitude. Bits 15:10 are ignored.
- R3: With the matrix selected, output component r equals clamp(round(sum over k of M[r][k]·in[k]) + offset[r]).
- R4: Rounding adds 512 to the full-precision sum and then shifts it arithmetically right by 10. Halves therefore round upward: +0.5 gives 1, −0.5 gives 0, 1.5 gives 2.
- R5: With `swap_c02` high, output components 0 and 2 are exchanged after conversion or bypass. Component 1 is unaffected.
- R6: With `mx_en` low, the pixel passes through unchanged, apart from any swap.
- R7: `out_valid`, `out_hs`, `out_vs` and `out_de` equal their inputs delayed by exactly three rising edges. A pixel's data appears in the same cycle as its valid.
- R8: Results below 0 saturate to 0 and results above 255 saturate to 255.
- R9: Reset clears all outputs to 0 and clears the whole bank to 0. With the matrix selected, a pixel converted by the cleared bank gives 0, 0, 0.
- R10: `mx_en` and `swap_c02` are sampled with each pixel and follow it through the pipeline, so the controls may change on every pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient byte write strobe |
| cfg_addr | input | 5 | Coefficient byte address |
| cfg_wdata | input | 8 | Coefficient byte data |
| mx_en | input | 1 | 1 = apply matrix, 0 = pass through |
| swap_c02 | input | 1 | Exchange output components 0 and 2 |
| in_valid | input | 1 | Input pixel valid |
| in_hs | input | 1 | Input line sync |
| in_vs | input | 1 | Input frame sync |
| in_de | input | 1 | Input data enable |
| in_c0 | input | 8 | Input component 0 |
| in_c1 | input | 8 | Input component 1 |
| in_c2 | input | 8 | Input component 2 |
| out_valid | output | 1 | Output pixel valid |
| out_hs | output | 1 | Delayed line sync |
| out_vs | output | 1 | Delayed frame sync |
| out_de | output | 1 | Delayed data enable |
| out_c0 | output | 8 | Output component 0 |
| out_c1 | output | 8 | Output component 1 |
| out_c2 | output | 8 | Output component 2 |

## Verification
The hardest case to reach from the ports is an exact rounding tie on a negative sum. Here a sign-magnitude multiplier yields exactly −0.5 before the offset, and the result must differ from symmetric rounding. The stimulus loads hand-built words with multiplier ±0.5 and drives odd component values to land on the tie. The same words set the ignored high bits, which exercises the field extraction. Random streams that flip the bypass and swap controls on every pixel confirm that the controls stay attached to their own pixel through all three stages.

// File: rtl/colour_matrix3.sv
module colour_matrix3 #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 10,
  parameter int AW     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             mx_en,
  input  logic             swap_c02,
  input  logic             in_valid,
  input  logic             in_hs,
  input  logic             in_vs,
  input  logic             in_de,
  input  logic [PIX_W-1:0] in_c0,
  input  logic [PIX_W-1:0] in_c1,
  input  logic [PIX_W-1:0] in_c2,
  output logic             out_valid,
  output logic             out_hs,
  output logic             out_vs,
  output logic             out_de,
  output logic [PIX_W-1:0] out_c0,
  output logic [PIX_W-1:0] out_c1,
  output logic [PIX_W-1:0] out_c2
);
  localparam int NB     = 24;
  localparam int MAG_W  = 12;
  localparam int MUL_W  = MAG_W + PIX_W;
  localparam int PROD_W = MUL_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam int OMAG_W = 9;

  logic [7:0] bank [NB];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) bank[i] <= '0;
    end else if (cfg_we && cfg_addr < AW'(NB)) begin
      bank[cfg_addr] <= cfg_wdata;
    end

  logic [PIX_W-1:0] pin  [3];
  logic [PIX_W-1:0] byp1 [3];
  logic [PIX_W-1:0] byp2 [3];
  logic [PIX_W-1:0] sel  [3];
  logic [3:0]       ctl1, ctl2;
  logic             en1, en2, sw1, sw2;

  assign pin[0] = in_c0;
  assign pin[1] = in_c1;
  assign pin[2] = in_c2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl1 <= '0;
      ctl2 <= '0;
      {en1, en2, sw1, sw2} <= '0;
      for (int k = 0; k < 3; k++) begin
        byp1[k] <= '0;
        byp2[k] <= '0;
      end
    end else begin
      ctl1 <= {in_valid, in_hs, in_vs, in_de};
      ctl2 <= ctl1;
      en1  <= mx_en;
      en2  <= en1;
      sw1  <= swap_c02;
      sw2  <= sw1;
      for (int k = 0; k < 3; k++) begin
        byp1[k] <= pin[k];
        byp2[k] <= byp1[k];
      end
    end

  for (genvar r = 0; r < 3; r++) begin : g_row
    logic [OMAG_W:0]          offw;
    logic signed [OMAG_W+1:0] offs;
    logic signed [SUM_W-1:0]  acc;
    logic signed [SUM_W-1:0]  q;
    logic [PIX_W-1:0]         conv;

    assign offw = {bank[8*r+6][1:0], bank[8*r+7]};
    assign offs = offw[OMAG_W] ? -$signed({2'b00, offw[OMAG_W-1:0]})
                               :  $signed({2'b00, offw[OMAG_W-1:0]});

    for (genvar k = 0; k < 3; k++) begin : g_tap
      logic [MAG_W:0]             w;
      logic [MUL_W-1:0]           mag;
      logic signed [PROD_W-1:0]   p;

      assign w   = {bank[8*r+2*k][4:0], bank[8*r+2*k+1]};
      assign mag = MUL_W'(w[MAG_W-1:0]) * MUL_W'(pin[k]);

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)          p <= '0;
        else if (w[MAG_W])   p <= -$signed({1'b0, mag});
        else                 p <=  $signed({1'b0, mag});
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) acc <= '0;
      else        acc <= SUM_W'(g_tap[0].p) + SUM_W'(g_tap[1].p) + SUM_W'(g_tap[2].p)
                         + SUM_W'(1 << (FRAC_W - 1));

    assign q    = (acc >>> FRAC_W) + SUM_W'(offs);
    assign conv = q[SUM_W-1] ? '0
                : (q > SUM_W'((1 << PIX_W) - 1)) ? '1
                : q[PIX_W-1:0];
    assign sel[r] = en2 ? conv : byp2[r];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {out_valid, out_hs, out_vs, out_de} <= '0;
      out_c0 <= '0;
      out_c1 <= '0;
      out_c2 <= '0;
    end else begin
      {out_valid, out_hs, out_vs, out_de} <= ctl2;
      out_c0 <= sw2 ? sel[2] : sel[0];
      out_c1 <= sel[1];
      out_c2 <= sw2 ? sel[0] : sel[2];
    end
endmodule

// File: rtl/colour_matrix3_chk.sv
module colour_matrix3_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mx_en,
  input logic             swap_c02,
  input logic             in_valid,
  input logic             in_hs,
  input logic             in_vs,
  input logic             in_de,
  input logic [PIX_W-1:0] in_c0,
  input logic [PIX_W-1:0] in_c1,
  input logic [PIX_W-1:0] in_c2,
  input logic             out_valid,
  input logic             out_hs,
  input logic             out_vs,
  input logic             out_de,
  input logic [PIX_W-1:0] out_c0,
  input logic [PIX_W-1:0] out_c1,
  input logic [PIX_W-1:0] out_c2
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> out_valid == $past(in_valid, 3));

  assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_hs == $past(in_hs, 3) && out_vs == $past(in_vs, 3)
                             && out_de == $past(in_de, 3)));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid && !mx_en && !swap_c02, 3)) |->
      (out_c0 == $past(in_c0, 3) && out_c1 == $past(in_c1, 3) && out_c2 == $past(in_c2, 3)));

  assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid && !mx_en && swap_c02, 3)) |->
      (out_c0 == $past(in_c2, 3) && out_c1 == $past(in_c1, 3) && out_c2 == $past(in_c0, 3)));

  always @(posedge clk)
    if (!rst_n)
      assert_reset_clear_R9: assert (!out_valid && !out_hs && !out_vs && !out_de
                                     && out_c0 == '0 && out_c1 == '0 && out_c2 == '0);
endmodule

bind colour_matrix3 colour_matrix3_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mx_en(mx_en), .swap_c02(swap_c02),
  .in_valid(in_valid), .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de),
  .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
  .out_valid(out_valid), .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de),
  .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
);

// File: tb/colour_matrix3_bench.sv
module colour_matrix3_bench;
  logic       clk = 0, rst_n = 0;
  logic       cfg_we = 0;
  logic [4:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic       mx_en = 0, swap_c02 = 0;
  logic       in_valid = 0, in_hs = 0, in_vs = 0, in_de = 0;
  logic [7:0] in_c0 = 0, in_c1 = 0, in_c2 = 0;
  logic       out_valid, out_hs, out_vs, out_de;
  logic [7:0] out_c0, out_c1, out_c2;

  always #10 clk = ~clk;

  colour_matrix3 u_colour_matrix3 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mx_en(mx_en), .swap_c02(swap_c02), .in_valid(in_valid), .in_hs(in_hs), .in_vs(in_vs),
    .in_de(in_de), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .out_valid(out_valid), .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de),
    .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2));

  typedef struct {
    bit v, hs, vs, de, en, sw, dir;
    int e0, e1, e2, d0, d1, d2;
    string tag;
  } ent_t;

  ent_t       hist [3];
  logic [7:0] bk [24];
  int         checks = 0, errors = 0;
  bit         done = 0;

  function automatic int clamp8(int x);
    return x < 0 ? 0 : (x > 255 ? 255 : x);
  endfunction

  function automatic void model(input int px0, px1, px2, input bit en, sw,
                                output int o0, output int o1, output int o2);
    int px [3];
    int o  [3];
    px[0] = px0; px[1] = px1; px[2] = px2;
    for (int r = 0; r < 3; r++) begin
      int s = 0;
      int off;
      logic [15:0] ow;
      for (int k = 0; k < 3; k++) begin
        logic [15:0] w;
        int m;
        w = {bk[8*r+2*k], bk[8*r+2*k+1]};
        m = int'(w[11:0]);
        if (w[12]) m = -m;
        s += m * px[k];
      end
      s = (s + 512) >>> 10;
      ow = {bk[8*r+6], bk[8*r+7]};
      off = int'(ow[8:0]);
      if (ow[9]) off = -off;
      o[r] = en ? clamp8(s + off) : px[r];
    end
    o0 = sw ? o[2] : o[0];
    o1 = o[1];
    o2 = sw ? o[0] : o[2];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input ent_t e);
    string mt;
    check("R7 ctrl {valid,hs,vs,de}", {out_valid, out_hs, out_vs, out_de}, {e.v, e.hs, e.vs, e.de});
    if (e.v) begin
      mt = !e.en ? (e.sw ? "R5 swap-bypass" : "R6 bypass") : (e.sw ? "R5 swap" : "R3 matrix");
      check({mt, " ", e.tag, " c0"}, out_c0, e.e0);
      check({mt, " ", e.tag, " c1"}, out_c1, e.e1);
      check({mt, " ", e.tag, " c2"}, out_c2, e.e2);
      if (e.dir) begin
        check({e.tag, " directed c0"}, out_c0, e.d0);
        check({e.tag, " directed c1"}, out_c1, e.d1);
        check({e.tag, " directed c2"}, out_c2, e.d2);
      end
    end
  endtask

  task automatic step(input bit v, hs, vs, de, en, sw, input int a, b, c,
                      input bit dir = 0, input int d0 = 0, input int d1 = 0, input int d2 = 0,
                      input string tag = "", input bit we = 0, input int wa = 0, input int wd = 0);
    ent_t n;
    @(negedge clk);
    compare(hist[2]);
    hist[2] = hist[1];
    hist[1] = hist[0];
    n.v = v; n.hs = hs; n.vs = vs; n.de = de; n.en = en; n.sw = sw; n.dir = dir;
    n.d0 = d0; n.d1 = d1; n.d2 = d2; n.tag = tag;
    model(a, b, c, en, sw, n.e0, n.e1, n.e2);
    hist[0] = n;
    in_valid = v; in_hs = hs; in_vs = vs; in_de = de; mx_en = en; swap_c02 = sw;
    in_c0 = 8'(a); in_c1 = 8'(b); in_c2 = 8'(c);
    cfg_we = we; cfg_addr = 5'(wa); cfg_wdata = 8'(wd);
    if (we && wa < 24) bk[wa] = 8'(wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic pix(input bit en, sw, input int a, b, c, input int d0, d1, d2, input string tag);
    step(1, 0, 0, 1, en, sw, a, b, c, 1, d0, d1, d2, tag);
  endtask

  task automatic wr(input int addr, input int data);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "", 1, addr, data);
  endtask

  function automatic logic [15:0] em(int x);
    return x < 0 ? (16'h1000 | 16'(-x)) : 16'(x);
  endfunction

  function automatic logic [15:0] eo(int x);
    return x < 0 ? (16'h0200 | 16'(-x)) : 16'(x);
  endfunction

  task automatic load_row(input int r, input logic [15:0] m0, m1, m2, off);
    logic [15:0] ws [4];
    ws[0] = m0; ws[1] = m1; ws[2] = m2; ws[3] = off;
    for (int k = 0; k < 4; k++) begin
      wr(8*r + 2*k, ws[k][15:8]);
      wr(8*r + 2*k + 1, ws[k][7:0]);
    end
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++)
      step(($urandom % 4) != 0, $urandom % 2, ($urandom % 16) == 0, $urandom % 2,
           $urandom % 2, $urandom % 2, $urandom % 256, $urandom % 256, $urandom % 256,
           0, 0, 0, 0, "R10");
    idle(3);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 24; i++) bk[i] = 8'h00;
    for (int i = 0; i < 3; i++) hist[i] = '{default: 0, tag: ""};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset valid", out_valid, 0);
    check("R9 reset c0", out_c0, 0);
    check("R9 reset c1", out_c1, 0);
    check("R9 reset c2", out_c2, 0);

    pix(1, 0, 9, 9, 9, 0, 0, 0, "R9 cleared bank");
    idle(3);
    pix(0, 0, 12, 34, 56, 12, 34, 56, "R6");
    pix(0, 1, 12, 34, 56, 56, 34, 12, "R5");
    idle(3);

    load_row(0, 16'h0200, 16'h0000, 16'h0000, 16'h0000);
    load_row(1, 16'h1200, 16'h0000, 16'h0000, 16'h000A);
    load_row(2, 16'h0000, 16'h0000, 16'hE400, 16'hFC05);
    idle(3);
    pix(1, 0, 1, 0, 7, 1, 10, 12, "R4 half ties");
    pix(1, 0, 3, 0, 7, 2, 9, 12, "R4 1.5 and -1.5");
    pix(1, 0, 0, 0, 200, 0, 10, 205, "R2 ignored high bits");
    idle(3);

    load_row(0, 16'h036F, 16'h0000, 16'h0000, eo(16));
    load_row(1, 16'h0000, 16'h036F, 16'h0000, eo(16));
    load_row(2, 16'h0000, 16'h0000, 16'h036F, eo(16));
    idle(3);
    pix(1, 0, 255, 0, 128, 235, 16, 126, "R3 range compress");
    pix(1, 1, 255, 0, 128, 126, 16, 235, "R5 swap after matrix");
    idle(3);
    for (int a = 24; a < 32; a++) wr(a, 8'hFF);
    idle(3);
    pix(1, 0, 255, 0, 128, 235, 16, 126, "R1 out-of-range writes ignored");
    idle(3);

    load_row(0, em(1192), em(0), em(1634), eo(-204));
    load_row(1, em(1192), em(-400), em(-833), eo(154));
    load_row(2, em(1192), em(2066), em(0), eo(-258));
    idle(3);
    pix(1, 0, 255, 128, 255, 255, 193, 255, "R8 high clamp");
    pix(1, 0, 0, 0, 0, 0, 154, 0, "R8 low clamp");
    idle(3);
    rand_run(1500);

    load_row(0, em(-298), em(-152), em(450), eo(128));
    load_row(1, em(516), em(263), em(100), eo(16));
    load_row(2, em(-377), em(450), em(-73), eo(128));
    idle(3);
    rand_run(1500);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule